// File: doc/BRIEF.md
# Display Gamma Lookup Table Write Port

This block is the host-facing write side of a display gamma lookup table that keeps two independent tables of 256 entries each. The first table holds one packed word per entry: red in bits 9:0, green in bits 19:10 and blue in bits 29:20, with bits 31:30 unused. The second table holds a piecewise-linear curve. Each of its entries has three 32-bit words, one each for red, green and blue. Every word carries a 16-bit base in its low half and a 16-bit delta in its high half.

The host programs three control registers through a single register write port: an entry index, a store-enable mask and a table-select mode. It then pushes data words through a fourth register address. In packed mode a data word replaces the whole entry. In piecewise-linear mode a rolling sub-index, which counts modulo three, steers successive words into the red, green and blue slots. The sub-index advances on every data push, including a push that the mask blocks.

Every data push raises a dirty flag, which a downstream consumer clears with an acknowledge pulse. A combinational read port returns any stored word so that the tables can be inspected.

Top module: `gamma_lut_wport`

## Requirements
- R1: After reset every word of both tables reads zero, the dirty flag is 1 and the sub-index is 0, so the first piecewise-linear push lands in red.
- R2: A register write with `reg_sel` = 0 loads the index from `reg_wdata[7:0]`. With `reg_sel` = 1 it loads the mask from `reg_wdata[5:0]`. With `reg_sel` = 2 it loads the mode from `reg_wdata[0]`. With `reg_sel` = 3 it is a data push.
- R3: In mode 0, a data push with mask bits 2:0 = 111 stores the full 32-bit word at packed entry [index]. The store is visible on the read port one clock later.
- R4: In mode 1, a data push with mask bits 2:0 = 111 stores the word in component [sub-index] of piecewise-linear entry [index], where component 0 is red, 1 is green and 2 is blue.
- R5: The sub-index steps 0→1→2→0 on every data push, whatever the mode and mask.
- R6: A data push whose mask bits 2:0 are anything other than 111 changes no stored word.
- R7: `mask_err` is 1 exactly while the held mask has bits 2:0 outside {000, 111} or any nonzero bit in 5:3.
- R8: Every data push sets `dirty` on the next clock. A `dirty_ack` pulse with no data push clears it. A push and an acknowledge in the same cycle leave it set.
- R9: A write to the index register resets the sub-index to 0.
- R10: The read port is combinational. `rd_mode` 0 returns packed entry [`rd_idx`] and ignores `rd_comp`. `rd_mode` 1 returns component `rd_comp` of piecewise-linear entry [`rd_idx`]. `rd_comp` = 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 mask, 2 mode, 3 data push |
| reg_wdata | input | 32 | Register write data |
| dirty_ack | input | 1 | Consumer acknowledge, clears the dirty flag |
| rd_mode | input | 1 | Read table select: 0 packed, 1 piecewise-linear |
| rd_idx | input | 8 | Read entry index |
| rd_comp | input | 2 | Read component for the piecewise-linear table |
| rd_data | output | 32 | Stored word at the read selection |
| dirty | output | 1 | Table contents changed since the last acknowledge |
| mask_err | output | 1 | Held mask value is unsupported |

## Verification
The sub-index is hidden state, so an error in it shows only when a later piecewise-linear push lands in the wrong component slot. The bench catches this on the read port one clock after that push, which can be several pushes after the fault, particularly across masked pushes and index writes. A store gated wrongly shows on the read port in the cycle after the push. A dirty flag that is updated wrongly shows on `dirty` in that same cycle. The bench compares every location it reads against a behavioural model on every clock.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_MASK  = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_DATA  = 2'd3
    } reg_sel_e;

    localparam int unsigned N_COMP   = 3;
    localparam int unsigned MASK_W   = 6;
    localparam int unsigned GATE_W   = 3;
endpackage

// File: rtl/gamma_lut_ctrl.sv
module gamma_lut_ctrl
    import gamma_lut_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              dirty_ack,
    output logic [IDX_W-1:0]  idx_o,
    output logic [1:0]        sub_o,
    output logic              store_norm_o,
    output logic              store_pwl_o,
    output logic              dirty_o,
    output logic              err_o
);
    localparam int unsigned HI_W = MASK_W - GATE_W;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [MASK_W-1:0] mask;
        logic              mode;
        logic [1:0]        sub;
        logic              dirty;
    } ctrl_t;

    ctrl_t    st_q, st_d;
    reg_sel_e sel;
    logic     push;
    logic     store_en;
    logic [GATE_W-1:0] gate_lo;
    logic [HI_W-1:0]   gate_hi;

    always_comb begin
        sel      = reg_sel_e'(reg_sel);
        st_d     = st_q;
        push     = reg_wr && (sel == SEL_DATA);
        store_en = (st_q.mask[GATE_W-1:0] == {GATE_W{1'b1}});
        if (reg_wr) begin
            case (sel)
                SEL_INDEX: begin
                    st_d.idx = reg_wdata[IDX_W-1:0];
                    st_d.sub = 2'd0;
                end
                SEL_MASK: st_d.mask = reg_wdata[MASK_W-1:0];
                SEL_MODE: st_d.mode = reg_wdata[0];
                default:  ;
            endcase
        end
        if (push) begin
            st_d.sub   = (st_q.sub == 2'(N_COMP - 1)) ? 2'd0 : st_q.sub + 2'd1;
            st_d.dirty = 1'b1;
        end else if (dirty_ack) begin
            st_d.dirty = 1'b0;
        end
        store_norm_o = push && store_en && !st_q.mode;
        store_pwl_o  = push && store_en && st_q.mode;
        gate_lo      = st_q.mask[GATE_W-1:0];
        gate_hi      = st_q.mask[MASK_W-1:GATE_W];
        err_o        = ((gate_lo != '0) && (gate_lo != {GATE_W{1'b1}})) || (gate_hi != '0);
        idx_o        = st_q.idx;
        sub_o        = st_q.sub;
        dirty_o      = st_q.dirty;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dirty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank #(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = (int'(raddr) < int'(DEPTH)) ? mem_q[raddr] : '0;
    end
endmodule

// File: rtl/gamma_lut_wport.sv
module gamma_lut_wport
    import gamma_lut_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 256,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              dirty_ack,
    input  logic              rd_mode,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [1:0]        rd_comp,
    output logic [DATA_W-1:0] rd_data,
    output logic              dirty,
    output logic              mask_err
);
    localparam int unsigned PWL_DEPTH = N_ENTRIES * N_COMP;
    localparam int unsigned PAW       = $clog2(PWL_DEPTH);

    logic [IDX_W-1:0]  idx_w;
    logic [1:0]        sub_w;
    logic              st_norm, st_pwl;
    logic [PAW-1:0]    pwl_waddr, pwl_raddr;
    logic [1:0]        rd_comp_safe;
    logic [DATA_W-1:0] norm_rd, pwl_rd;

    gamma_lut_ctrl #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dirty_ack(dirty_ack), .idx_o(idx_w),
        .sub_o(sub_w), .store_norm_o(st_norm), .store_pwl_o(st_pwl),
        .dirty_o(dirty), .err_o(mask_err)
    );

    always_comb begin
        rd_comp_safe = (rd_comp == 2'd3) ? 2'd0 : rd_comp;
        pwl_waddr    = PAW'(idx_w) * PAW'(N_COMP) + PAW'(sub_w);
        pwl_raddr    = PAW'(rd_idx) * PAW'(N_COMP) + PAW'(rd_comp_safe);
    end

    gamma_lut_bank #(.DEPTH(N_ENTRIES), .WIDTH(DATA_W)) i_norm (
        .clk(clk), .rst_n(rst_n), .we(st_norm), .waddr(idx_w),
        .wdata(reg_wdata), .raddr(rd_idx), .rdata(norm_rd)
    );

    gamma_lut_bank #(.DEPTH(PWL_DEPTH), .WIDTH(DATA_W)) i_pwl (
        .clk(clk), .rst_n(rst_n), .we(st_pwl), .waddr(pwl_waddr),
        .wdata(reg_wdata), .raddr(pwl_raddr), .rdata(pwl_rd)
    );

    always_comb begin
        if (!rd_mode)              rd_data = norm_rd;
        else if (rd_comp == 2'd3)  rd_data = '0;
        else                       rd_data = pwl_rd;
    end
endmodule

// File: rtl/gamma_lut_wport_chk.sv
module gamma_lut_wport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic       ack,
    input logic       dirty,
    input logic [1:0] sub
);
    logic push;
    assign push = reg_wr && (reg_sel == 2'd3);

    assert_dirty_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> dirty);

    assert_dirty_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !push) |=> !dirty);

    assert_sub_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (sub == (($past(sub) == 2'd2) ? 2'd0 : $past(sub) + 2'd1)));

    assert_sub_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sub != 2'd3);

    assert_index_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> (sub == 2'd0));
endmodule

bind gamma_lut_wport gamma_lut_wport_chk i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .ack(dirty_ack), .dirty(dirty), .sub(sub_w)
);

// File: tb/test_gamma_lut_wport.sv
module test_gamma_lut_wport;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic        dirty_ack = 1'b0;
    logic        rd_mode = 1'b0;
    logic [7:0]  rd_idx = '0;
    logic [1:0]  rd_comp = '0;
    logic [31:0] rd_data;
    logic        dirty, mask_err;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_norm [256];
    logic [31:0] m_pwl  [768];
    int          m_idx = 0, m_sub = 0;
    logic [5:0]  m_mask = '0;
    logic        m_mode = 1'b0, m_dirty = 1'b1;

    always #4 clk = ~clk;

    gamma_lut_wport i_gamma_lut_wport (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dirty_ack(dirty_ack), .rd_mode(rd_mode),
        .rd_idx(rd_idx), .rd_comp(rd_comp), .rd_data(rd_data),
        .dirty(dirty), .mask_err(mask_err)
    );

    function automatic logic [31:0] exp_rd(logic md, logic [7:0] ix, logic [1:0] cp);
        if (!md) return m_norm[ix];
        if (cp == 2'd3) return 32'h0;
        return m_pwl[int'(ix) * 3 + int'(cp)];
    endfunction

    function automatic logic exp_err();
        return ((m_mask[2:0] != 3'd0) && (m_mask[2:0] != 3'd7)) || (m_mask[5:3] != 3'd0);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk({tag, " R8 dirty"}, 32'(dirty), 32'(m_dirty));
        chk({tag, " R7 mask_err"}, 32'(mask_err), 32'(exp_err()));
        chk({tag, " R10 rd_data"}, rd_data, exp_rd(rd_mode, rd_idx, rd_comp));
    endtask

    task automatic step(input logic wr, input logic [1:0] sel, input logic [31:0] d,
                        input logic ak, input string tag);
        reg_wr = wr; reg_sel = sel; reg_wdata = d; dirty_ack = ak;
        @(posedge clk);
        #1;
        if (wr) begin
            case (sel)
                2'd0: begin m_idx = int'(d[7:0]); m_sub = 0; end
                2'd1: m_mask = d[5:0];
                2'd2: m_mode = d[0];
                default: begin
                    if (m_mask[2:0] == 3'd7) begin
                        if (!m_mode) m_norm[m_idx] = d;
                        else m_pwl[m_idx * 3 + m_sub] = d;
                    end
                    m_sub = (m_sub + 1) % 3;
                end
            endcase
        end
        if (wr && sel == 2'd3) m_dirty = 1'b1;
        else if (ak) m_dirty = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; dirty_ack = 1'b0;
        compare_all(tag);
    endtask

    task automatic probe(logic md, logic [7:0] ix, logic [1:0] cp, logic [31:0] exp, string tag);
        rd_mode = md; rd_idx = ix; rd_comp = cp;
        #1;
        chk(tag, rd_data, exp);
        chk({tag, " model"}, rd_data, exp_rd(md, ix, cp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) m_norm[i] = '0;
        for (int i = 0; i < 768; i++) m_pwl[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        probe(1'b0, 8'd0, 2'd0, 32'h0, "R1 norm[0] zero");
        probe(1'b1, 8'd255, 2'd2, 32'h0, "R1 pwl[255].b zero");
        chk("R1 dirty in reset", 32'(dirty), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 after reset");

        // R8: ack clears
        step(1'b0, 2'd0, 32'h0, 1'b1, "R8 ack");
        chk("R8 cleared by ack", 32'(dirty), 32'd0);

        // R2/R3: packed write
        step(1'b1, 2'd1, 32'h7, 1'b0, "R2 mask");
        step(1'b1, 2'd2, 32'h2, 1'b0, "R2 mode bit0 only");
        step(1'b1, 2'd0, 32'h105, 1'b0, "R2 index low bits");
        step(1'b1, 2'd3, 32'hC0A5_5A3C, 1'b0, "R3 push");
        probe(1'b0, 8'd5, 2'd2, 32'hC0A5_5A3C, "R3 norm[5]");
        chk("R8 set by push", 32'(dirty), 32'd1);

        // R4: PWL triple
        step(1'b1, 2'd2, 32'h1, 1'b0, "R2 mode pwl");
        step(1'b1, 2'd0, 32'h5, 1'b0, "R9 index");
        step(1'b1, 2'd3, 32'h0011_0010, 1'b0, "R4 red");
        step(1'b1, 2'd3, 32'h0022_0020, 1'b0, "R4 green");
        step(1'b1, 2'd3, 32'h0033_0030, 1'b0, "R4 blue");
        probe(1'b1, 8'd5, 2'd0, 32'h0011_0010, "R4 red slot");
        probe(1'b1, 8'd5, 2'd1, 32'h0022_0020, "R4 green slot");
        probe(1'b1, 8'd5, 2'd2, 32'h0033_0030, "R4 blue slot");
        probe(1'b0, 8'd5, 2'd0, 32'hC0A5_5A3C, "R4 packed untouched");
        probe(1'b1, 8'd5, 2'd3, 32'h0, "R10 comp 3 zero");
        // R5: wrap to red
        step(1'b1, 2'd3, 32'h0044_0040, 1'b0, "R5 wrap");
        probe(1'b1, 8'd5, 2'd0, 32'h0044_0040, "R5 wrapped to red");

        // R6 + R5: masked push advances sub-index
        step(1'b1, 2'd0, 32'h9, 1'b0, "R9 index 9");
        step(1'b1, 2'd1, 32'h0, 1'b0, "R6 mask off");
        step(1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0, "R6 masked push");
        probe(1'b1, 8'd9, 2'd0, 32'h0, "R6 red not stored");
        step(1'b1, 2'd1, 32'h7, 1'b0, "R6 mask on");
        step(1'b1, 2'd3, 32'h1234_5678, 1'b0, "R5 after masked");
        probe(1'b1, 8'd9, 2'd1, 32'h1234_5678, "R5 landed in green");
        probe(1'b1, 8'd9, 2'd0, 32'h0, "R5 red still empty");

        // R9: index write restarts at red
        step(1'b1, 2'd0, 32'h9, 1'b0, "R9 rewrite index");
        step(1'b1, 2'd3, 32'hAAAA_5555, 1'b0, "R9 push");
        probe(1'b1, 8'd9, 2'd0, 32'hAAAA_5555, "R9 restart at red");

        // R7: error flag and R6 with partial mask
        step(1'b1, 2'd1, 32'h3, 1'b0, "R7 partial");
        chk("R7 partial mask err", 32'(mask_err), 32'd1);
        step(1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, "R6 partial push");
        probe(1'b1, 8'd9, 2'd1, 32'h1234_5678, "R6 partial mask no store");
        step(1'b1, 2'd1, 32'hF, 1'b0, "R7 high bit");
        chk("R7 high bits err", 32'(mask_err), 32'd1);
        step(1'b1, 2'd1, 32'h7, 1'b0, "R7 ok");
        chk("R7 full mask ok", 32'(mask_err), 32'd0);

        // R8: push and ack together
        step(1'b1, 2'd3, 32'h0, 1'b1, "R8 push+ack");
        chk("R8 stays set", 32'(dirty), 32'd1);
        step(1'b0, 2'd0, 32'h0, 1'b1, "R8 ack again");
        chk("R8 clears", 32'(dirty), 32'd0);

        // mixed traffic compared every clock
        for (int n = 0; n < 2000; n++) begin
            logic [31:0] r;
            logic [1:0]  s;
            logic [31:0] d;
            r = $urandom;
            s = r[1:0];
            d = $urandom;
            if (s == 2'd1) d = {26'd0, r[8] ? 6'h07 : (r[9] ? 6'h00 : r[15:10])};
            if (s == 2'd0 && r[16]) d[7:0] = 8'd255;
            rd_mode = r[17];
            rd_idx  = r[18] ? 8'(m_idx) : r[31:24];
            rd_comp = r[20:19];
            step(r[21] | r[22], s, d, r[23] & r[7], "R3/R4 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule